// File: doc/BRIEF.md
# Statistics Counter Update Engine

The block takes 32-bit update commands, one per ready/valid handshake. It applies increment and add operations to statistics storage. A command selects one of two targets.

A counter command addresses a group of four 32-bit counters. Each group holds a packet counter and a byte counter for the pre-queue side, and the same pair for the post-queue side. A register command addresses a 64-word file of system-wide counts.

Group indices below 128 live in flip-flop storage inside the block, and each update there finishes in one clock cycle. Higher indices live in an external SRAM. The block reaches it through a request/acknowledge port by reading the word, then writing it back. The command input is held off until the last write is acknowledged. A registered read port returns any on-chip counter or register word one cycle after it is requested. Malformed commands are discarded and counted in an error counter that is visible at the ports.

Top module: `stat_engine`

## Requirements
- R1: The command word carries the opcode in bits [31:28], an unsigned 12-bit addend in [27:16] and an index in [15:0]. Opcode bit 3 = 0 selects a counter group. Opcode bit 2 picks the post-queue pair (1) or the pre-queue pair (0). Inside a group, word 0 is the pre packet count, 1 the pre byte count, 2 the post packet count and 3 the post byte count.
- R2: In a counter command, opcode bit 1 adds 1 to the packet word of the selected pair. Opcode bit 0 adds the zero-extended addend to the byte word. When both bits are set, both updates happen in the same command.
- R3: Opcodes 1001, 1010 and 1011 update the register file at index[5:0]. 1010 adds 1 and 1001 adds the addend. 1011 adds 1 to word {index[5:1],0} and adds the addend to word {index[5:1],1}.
- R4: A register command whose index bits [15:6] are not all zero changes no register and raises err_count by 1.
- R5: The legal opcodes are 0001, 0010, 0011, 0101, 0110, 0111, 1001, 1010 and 1011. Any other opcode is accepted and then discarded. It changes no counter or register and raises err_count by 1.
- R6: All counters are 32 bits wide and wrap modulo 2^32.
- R7: A command that follows another to the same word sees the earlier result, both on chip and in the external tier. A fast command is applied at the clock edge that accepts it, so cmd_ready stays high through a run of fast commands.
- R8: A counter command with index 128 or above goes to the external port. For each word it issues a read (ext_wr=0) and then a write (ext_wr=1). The packet word goes first and the byte word second. The word address is {index, pair bit, word bit}, where the word bit is 0 for packet and 1 for byte. cmd_ready stays low from acceptance until the last write is acknowledged.
- R9: While ext_req is high and ext_ack is low, ext_req, ext_wr, ext_addr and ext_wdata stay unchanged.
- R10: A pulse on rd_en returns data one cycle later, with rd_valid high for that one cycle. With rd_space=0, rd_addr[8:0] = {index[6:0], word[1:0]} selects an on-chip counter word. With rd_space=1, rd_addr[5:0] selects a register word.
- R11: Synchronous active-low reset clears all on-chip counters, all registers and err_count. It leaves cmd_ready high and ext_req low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command word is present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_word | input | 32 | Opcode, addend and index |
| rd_en | input | 1 | Read request |
| rd_space | input | 1 | 0 selects on-chip counters, 1 selects registers |
| rd_addr | input | 9 | Word address for the read |
| rd_valid | output | 1 | rd_data holds read data |
| rd_data | output | 32 | Read data |
| err_count | output | 32 | Count of discarded commands |
| ext_req | output | 1 | External access request |
| ext_wr | output | 1 | 1 for a write access, 0 for a read access |
| ext_addr | output | 18 | External word address |
| ext_wdata | output | 32 | External write data |
| ext_rdata | input | 32 | External read data, valid with ext_ack |
| ext_ack | input | 1 | External access done |

## Verification
The bench sends both-bit commands, first to counters and then to register pairs. A design that mixed up the pair or word selection would put the addend on the packet word, or would touch the odd register alone. It sends runs of back-to-back commands to one index on both tiers. Losing a read-modify-write there would show up as a counter total that comes out short.

The bench also sends opcodes that look nearly legal, and register commands with upper index bits set. A design that decoded too loosely would write a counter or register instead of counting an error. For the external tier, it presets a word to all ones and logs the access order and address stability. This exposes missing wrap, a byte-before-packet order, a cmd_ready that drops too early, and a request that changes before it is acknowledged.

// File: rtl/stat_engine_pkg.sv
// Shared definitions for the statistics update engine.
// Assumes a 4-bit opcode whose legality is fixed by this package.
package stat_engine_pkg;

    typedef enum logic [1:0] {
        SLOW_IDLE  = 2'd0,
        SLOW_READ  = 2'd1,
        SLOW_WRITE = 2'd2
    } slow_state_e;

    // Legal opcode set: counter ops with at least one action, and register ops.
    function automatic logic op_is_legal(input logic [3:0] op);
        case (op)
            4'b0001, 4'b0010, 4'b0011,
            4'b0101, 4'b0110, 4'b0111,
            4'b1001, 4'b1010, 4'b1011: op_is_legal = 1'b1;
            default:                   op_is_legal = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/stat_cmd_decode.sv
// Combinational command decoder.
// Splits a command word into target class and word addresses.
// Assumes FAST_GROUPS and REG_WORDS are powers of two.
module stat_cmd_decode
    import stat_engine_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int IDX_W       = 16,
    parameter int FAST_GROUPS = 128,
    parameter int REG_WORDS   = 64,
    localparam int CMD_W   = 4 + DATA_W + IDX_W,
    localparam int GRP_AW  = $clog2(FAST_GROUPS),
    localparam int FAST_AW = GRP_AW + 2,
    localparam int REG_AW  = $clog2(REG_WORDS)
) (
    input  logic [CMD_W-1:0]   cmd,
    output logic               drop,
    output logic               to_fast,
    output logic               to_reg,
    output logic               to_slow,
    output logic               inc_en,
    output logic               add_en,
    output logic [FAST_AW-1:0] cnt_inc_addr,
    output logic [FAST_AW-1:0] cnt_add_addr,
    output logic [REG_AW-1:0]  reg_inc_addr,
    output logic [REG_AW-1:0]  reg_add_addr,
    output logic [DATA_W-1:0]  addend,
    output logic [IDX_W:0]     slow_base
);

    logic [3:0]       op;
    logic [IDX_W-1:0] idx;
    logic             legal;
    logic             reg_idx_ok;
    logic             fast_idx;

    // Field extraction and class decision.
    always_comb begin
        op         = cmd[CMD_W-1 -: 4];
        addend     = cmd[IDX_W +: DATA_W];
        idx        = cmd[IDX_W-1:0];
        legal      = op_is_legal(op);
        reg_idx_ok = ((idx >> REG_AW) == '0);
        fast_idx   = (idx < IDX_W'(FAST_GROUPS));
        to_reg     = legal && op[3] && reg_idx_ok;
        to_fast    = legal && !op[3] && fast_idx;
        to_slow    = legal && !op[3] && !fast_idx;
        drop       = !legal || (op[3] && !reg_idx_ok);
        inc_en     = op[1];
        add_en     = op[0];
        slow_base  = {idx, op[2]};
    end

    // Word addresses for both target classes.
    always_comb begin
        cnt_inc_addr = {idx[GRP_AW-1:0], op[2], 1'b0};
        cnt_add_addr = {idx[GRP_AW-1:0], op[2], 1'b1};
        if (op[1] && op[0]) begin
            reg_inc_addr = {idx[REG_AW-1:1], 1'b0};
            reg_add_addr = {idx[REG_AW-1:1], 1'b1};
        end else begin
            reg_inc_addr = idx[REG_AW-1:0];
            reg_add_addr = idx[REG_AW-1:0];
        end
    end

endmodule

// File: rtl/stat_fast_bank.sv
// On-chip counter groups and register file with single-cycle update.
// Also holds the registered read port.
// Assumes the increment and add addresses never coincide in one update.
// The decoder guarantees this.
module stat_fast_bank #(
    parameter int CNT_W       = 32,
    parameter int DATA_W      = 12,
    parameter int FAST_GROUPS = 128,
    parameter int REG_WORDS   = 64,
    localparam int FAST_WORDS = FAST_GROUPS * 4,
    localparam int FAST_AW    = $clog2(FAST_WORDS),
    localparam int REG_AW     = $clog2(REG_WORDS),
    localparam int BANK_AW    = (FAST_AW > REG_AW) ? FAST_AW : REG_AW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_we,
    input  logic               reg_we,
    input  logic               inc_en,
    input  logic               add_en,
    input  logic [FAST_AW-1:0] cnt_inc_addr,
    input  logic [FAST_AW-1:0] cnt_add_addr,
    input  logic [REG_AW-1:0]  reg_inc_addr,
    input  logic [REG_AW-1:0]  reg_add_addr,
    input  logic [DATA_W-1:0]  addend,
    input  logic               rd_en,
    input  logic               rd_space,
    input  logic [BANK_AW-1:0] rd_addr,
    output logic               rd_valid,
    output logic [CNT_W-1:0]   rd_data
);

    logic [CNT_W-1:0] cnt_mem [FAST_WORDS];
    logic [CNT_W-1:0] reg_mem [REG_WORDS];
    logic [CNT_W-1:0] add_ext;

    assign add_ext = {{(CNT_W-DATA_W){1'b0}}, addend};

    // Read-modify-write of the counter groups.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < FAST_WORDS; i++) cnt_mem[i] <= '0;
        end else if (cnt_we) begin
            if (inc_en) cnt_mem[cnt_inc_addr] <= cnt_mem[cnt_inc_addr] + CNT_W'(1);
            if (add_en) cnt_mem[cnt_add_addr] <= cnt_mem[cnt_add_addr] + add_ext;
        end
    end

    // Read-modify-write of the register file.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_WORDS; i++) reg_mem[i] <= '0;
        end else if (reg_we) begin
            if (inc_en) reg_mem[reg_inc_addr] <= reg_mem[reg_inc_addr] + CNT_W'(1);
            if (add_en) reg_mem[reg_add_addr] <= reg_mem[reg_add_addr] + add_ext;
        end
    end

    // Registered read port, one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_space ? reg_mem[rd_addr[REG_AW-1:0]]
                                           : cnt_mem[rd_addr[FAST_AW-1:0]];
        end
    end

endmodule

// File: rtl/stat_slow_port.sv
// Read-modify-write sequencer for counter groups held in external SRAM.
// Handles the packet word first, then the byte word.
// Assumes the external side holds ext_rdata valid in the cycle ext_ack is high.
module stat_slow_port
    import stat_engine_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 12,
    parameter int IDX_W  = 16,
    localparam int EXT_AW = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W:0]    base,
    input  logic              inc_en,
    input  logic              add_en,
    input  logic [DATA_W-1:0] addend,
    output logic              busy,
    output logic              ext_req,
    output logic              ext_wr,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [CNT_W-1:0]  ext_wdata,
    input  logic [CNT_W-1:0]  ext_rdata,
    input  logic              ext_ack
);

    slow_state_e       state;
    logic [IDX_W:0]    base_q;
    logic              want_add;
    logic              cur_byte;
    logic [DATA_W-1:0] addend_q;
    logic [CNT_W-1:0]  hold;

    // Sequencer: capture the command, then read and write each word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SLOW_IDLE;
            base_q   <= '0;
            want_add <= 1'b0;
            cur_byte <= 1'b0;
            addend_q <= '0;
            hold     <= '0;
        end else begin
            case (state)
                SLOW_IDLE: if (start) begin
                    base_q   <= base;
                    want_add <= add_en;
                    cur_byte <= !inc_en;
                    addend_q <= addend;
                    state    <= SLOW_READ;
                end
                SLOW_READ: if (ext_ack) begin
                    hold  <= ext_rdata + (cur_byte ? {{(CNT_W-DATA_W){1'b0}}, addend_q}
                                                   : CNT_W'(1));
                    state <= SLOW_WRITE;
                end
                SLOW_WRITE: if (ext_ack) begin
                    if (!cur_byte && want_add) begin
                        cur_byte <= 1'b1;
                        state    <= SLOW_READ;
                    end else begin
                        state <= SLOW_IDLE;
                    end
                end
                default: state <= SLOW_IDLE;
            endcase
        end
    end

    // External port driven straight from the sequencer state.
    always_comb begin
        busy      = (state != SLOW_IDLE);
        ext_req   = busy;
        ext_wr    = (state == SLOW_WRITE);
        ext_addr  = {base_q, cur_byte};
        ext_wdata = hold;
    end

endmodule

// File: rtl/stat_engine.sv
// Top of the statistics update engine.
// Accepts one command per handshake, routes it to the on-chip bank or the
// external sequencer, and counts discarded commands.
// Assumes one command source; arbitration between sources is done upstream.
module stat_engine
    import stat_engine_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int DATA_W      = 12,
    parameter int IDX_W       = 16,
    parameter int FAST_GROUPS = 128,
    parameter int REG_WORDS   = 64,
    localparam int CMD_W   = 4 + DATA_W + IDX_W,
    localparam int FAST_AW = $clog2(FAST_GROUPS * 4),
    localparam int REG_AW  = $clog2(REG_WORDS),
    localparam int BANK_AW = (FAST_AW > REG_AW) ? FAST_AW : REG_AW,
    localparam int EXT_AW  = IDX_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [CMD_W-1:0]   cmd_word,
    input  logic               rd_en,
    input  logic               rd_space,
    input  logic [BANK_AW-1:0] rd_addr,
    output logic               rd_valid,
    output logic [CNT_W-1:0]   rd_data,
    output logic [CNT_W-1:0]   err_count,
    output logic               ext_req,
    output logic               ext_wr,
    output logic [EXT_AW-1:0]  ext_addr,
    output logic [CNT_W-1:0]   ext_wdata,
    input  logic [CNT_W-1:0]   ext_rdata,
    input  logic               ext_ack
);

    logic               drop, to_fast, to_reg, to_slow, inc_en, add_en;
    logic [FAST_AW-1:0] cnt_inc_addr, cnt_add_addr;
    logic [REG_AW-1:0]  reg_inc_addr, reg_add_addr;
    logic [DATA_W-1:0]  addend;
    logic [IDX_W:0]     slow_base;
    logic               slow_busy;
    logic               accept;

    assign cmd_ready = !slow_busy;
    assign accept    = cmd_valid && cmd_ready;

    stat_cmd_decode #(
        .DATA_W(DATA_W), .IDX_W(IDX_W),
        .FAST_GROUPS(FAST_GROUPS), .REG_WORDS(REG_WORDS)
    ) i_decode (
        .cmd(cmd_word), .drop(drop), .to_fast(to_fast), .to_reg(to_reg),
        .to_slow(to_slow), .inc_en(inc_en), .add_en(add_en),
        .cnt_inc_addr(cnt_inc_addr), .cnt_add_addr(cnt_add_addr),
        .reg_inc_addr(reg_inc_addr), .reg_add_addr(reg_add_addr),
        .addend(addend), .slow_base(slow_base)
    );

    stat_fast_bank #(
        .CNT_W(CNT_W), .DATA_W(DATA_W),
        .FAST_GROUPS(FAST_GROUPS), .REG_WORDS(REG_WORDS)
    ) i_fast (
        .clk(clk), .rst_n(rst_n),
        .cnt_we(accept && to_fast), .reg_we(accept && to_reg),
        .inc_en(inc_en), .add_en(add_en),
        .cnt_inc_addr(cnt_inc_addr), .cnt_add_addr(cnt_add_addr),
        .reg_inc_addr(reg_inc_addr), .reg_add_addr(reg_add_addr),
        .addend(addend), .rd_en(rd_en), .rd_space(rd_space),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    stat_slow_port #(
        .CNT_W(CNT_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) i_slow (
        .clk(clk), .rst_n(rst_n), .start(accept && to_slow),
        .base(slow_base), .inc_en(inc_en), .add_en(add_en), .addend(addend),
        .busy(slow_busy), .ext_req(ext_req), .ext_wr(ext_wr),
        .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata), .ext_ack(ext_ack)
    );

    // Generic error counter for discarded commands.
    always_ff @(posedge clk) begin
        if (!rst_n)             err_count <= '0;
        else if (accept && drop) err_count <= err_count + CNT_W'(1);
    end

endmodule

// File: rtl/stat_engine_chk.sv
// Protocol checker for the statistics update engine, bound to its top.
module stat_engine_chk #(
    parameter int CNT_W  = 32,
    parameter int EXT_AW = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [CNT_W-1:0]  err_count,
    input logic              ext_req,
    input logic              ext_wr,
    input logic [EXT_AW-1:0] ext_addr,
    input logic [CNT_W-1:0]  ext_wdata,
    input logic              ext_ack
);

    // R11
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cmd_ready && !ext_req && err_count == '0));

    // R8
    slow_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> !cmd_ready);

    // R8
    req_starts_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_req) |-> $past(cmd_valid && cmd_ready));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr) && $stable(ext_wr)
                                   && $stable(ext_wdata)));

    // R10
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R10
    rd_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R5
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_count) |-> (err_count == $past(err_count) + CNT_W'(1)));

endmodule

bind stat_engine stat_engine_chk #(.CNT_W(CNT_W), .EXT_AW(EXT_AW)) i_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .rd_en(rd_en), .rd_valid(rd_valid), .err_count(err_count),
    .ext_req(ext_req), .ext_wr(ext_wr), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_ack(ext_ack)
);

// File: tb/test_stat_engine.sv
// Scoreboard bench for stat_engine: the read task queues expected words,
// and the monitor compares them as rd_valid comes back.
module test_stat_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_word = '0;
    logic        rd_en = 1'b0;
    logic        rd_space = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [31:0] err_count;
    logic        ext_req, ext_wr;
    logic [17:0] ext_addr;
    logic [31:0] ext_wdata;
    logic [31:0] ext_rdata = '0;
    logic        ext_ack = 1'b0;

    always #10 clk = ~clk;

    stat_engine i_stat_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_word(cmd_word), .rd_en(rd_en), .rd_space(rd_space), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .err_count(err_count),
        .ext_req(ext_req), .ext_wr(ext_wr), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .ext_ack(ext_ack)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_cnt [512];
    logic [31:0] exp_reg [64];
    logic [31:0] sram [int];
    logic [31:0] exp_sram [int];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic [18:0] log_q [$];
    int          hold_errs = 0;
    bit          ready_dropped = 0;
    bit          watch_ready = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Model of the command semantics, updated as each command is sent.
    task automatic model(input logic [3:0] op, input logic [11:0] d, input logic [15:0] idx);
        int b;
        bit legal = (op inside {4'b0001, 4'b0010, 4'b0011, 4'b0101, 4'b0110,
                                4'b0111, 4'b1001, 4'b1010, 4'b1011});
        if (!legal || (op[3] && idx[15:6] != 0)) return;
        if (op[3]) begin
            if (op[1] && op[0]) begin
                b = {idx[5:1], 1'b0};
                exp_reg[b] += 1;
                exp_reg[b+1] += 32'(d);
            end else if (op[1]) exp_reg[idx[5:0]] += 1;
            else exp_reg[idx[5:0]] += 32'(d);
        end else if (idx < 128) begin
            b = idx * 4 + op[2] * 2;
            if (op[1]) exp_cnt[b] += 1;
            if (op[0]) exp_cnt[b+1] += 32'(d);
        end else begin
            b = idx * 4 + op[2] * 2;
            if (!exp_sram.exists(b)) exp_sram[b] = 0;
            if (!exp_sram.exists(b+1)) exp_sram[b+1] = 0;
            if (op[1]) exp_sram[b] += 1;
            if (op[0]) exp_sram[b+1] += 32'(d);
        end
    endtask

    // Driver: caller is at a negedge; holds the command until accepted.
    task automatic send(input logic [3:0] op, input logic [11:0] d, input logic [15:0] idx);
        bit rdy;
        cmd_valid = 1'b1;
        cmd_word  = {op, d, idx};
        model(op, d, idx);
        forever begin
            rdy = cmd_ready;
            @(negedge clk);
            if (rdy) break;
        end
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!cmd_ready) @(negedge clk);
    endtask

    // Read request: queues the expected word for the monitor.
    task automatic rd(input bit space, input int addr, input string tag);
        rd_en    = 1'b1;
        rd_space = space;
        rd_addr  = 9'(addr);
        exp_q.push_back(space ? exp_reg[addr] : exp_cnt[addr]);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: compares returned read data with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) check("R10 unexpected rd_valid", 32'd1, 32'd0);
            else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
        if (watch_ready && !cmd_ready) ready_dropped = 1;
    end

    // External SRAM model: answers each access on its third cycle of waiting.
    int wcnt = 0;
    logic [17:0] l_addr;
    logic        l_wr;
    logic [31:0] l_wd;
    always @(negedge clk) begin
        if (!rst_n || ext_ack) begin
            ext_ack = 1'b0;
            wcnt = 0;
        end else if (ext_req) begin
            if (wcnt == 0) begin
                l_addr = ext_addr; l_wr = ext_wr; l_wd = ext_wdata;
            end else if (ext_addr != l_addr || ext_wr != l_wr || ext_wdata != l_wd) begin
                hold_errs++;
            end
            wcnt++;
            if (wcnt == 3) begin
                ext_ack = 1'b1;
                log_q.push_back({ext_wr, ext_addr});
                if (ext_wr) sram[int'(ext_addr)] = ext_wdata;
                else ext_rdata = sram.exists(int'(ext_addr)) ? sram[int'(ext_addr)] : 32'd0;
            end
        end
    end

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        foreach (exp_cnt[i]) exp_cnt[i] = 0;
        foreach (exp_reg[i]) exp_reg[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        check("R11 cmd_ready after reset", 32'(cmd_ready), 32'd1);
        check("R11 ext_req after reset", 32'(ext_req), 32'd0);
        check("R11 err_count after reset", err_count, 32'd0);
        rd(0, 21, "R11 counter cleared");
        rd(1, 3, "R11 register cleared");

        // R1 R2 counter groups, both pairs, each action bit
        send(4'b0010, 12'd0, 16'd5);
        send(4'b0001, 12'd100, 16'd5);
        send(4'b0011, 12'd7, 16'd5);
        send(4'b0111, 12'hFFF, 16'd127);
        send(4'b0110, 12'd0, 16'd64);
        send(4'b0101, 12'd9, 16'd64);
        @(negedge clk);
        for (int w = 0; w < 4; w++) rd(0, 5*4 + w, "R1 R2 group 5");
        for (int w = 0; w < 4; w++) rd(0, 127*4 + w, "R1 R2 group 127");
        for (int w = 0; w < 4; w++) rd(0, 64*4 + w, "R1 R2 group 64");

        // R3 register file
        send(4'b1010, 12'd0, 16'd7);
        send(4'b1001, 12'd30, 16'd7);
        send(4'b1011, 12'd200, 16'd9);
        send(4'b1011, 12'd5, 16'd8);
        @(negedge clk);
        for (int w = 6; w < 11; w++) rd(1, w, "R3 register words");

        // R4 register index with upper bits set
        send(4'b1010, 12'd0, 16'h0047);
        send(4'b1001, 12'd3, 16'h4009);
        @(negedge clk);
        rd(1, 7, "R4 register 7 untouched");
        rd(1, 9, "R4 register 9 untouched");
        check("R4 err_count", err_count, 32'd2);

        // R5 illegal opcodes
        send(4'b0000, 12'd50, 16'd5);
        send(4'b0100, 12'd50, 16'd5);
        send(4'b1000, 12'd50, 16'd5);
        send(4'b1100, 12'd50, 16'd5);
        send(4'b1111, 12'd50, 16'd5);
        @(negedge clk);
        check("R5 err_count", err_count, 32'd7);
        for (int w = 0; w < 4; w++) rd(0, 5*4 + w, "R5 group 5 untouched");
        for (int w = 4; w < 6; w++) rd(1, w, "R5 registers untouched");

        // R7 back-to-back fast commands to one index
        watch_ready = 1;
        for (int k = 0; k < 10; k++) send(4'b0011, 12'd3, 16'd12);
        for (int k = 0; k < 4; k++) send(4'b1011, 12'd11, 16'd2);
        watch_ready = 0;
        check("R7 cmd_ready held high", 32'(ready_dropped), 32'd0);
        @(negedge clk);
        rd(0, 48, "R7 back-to-back packet");
        rd(0, 49, "R7 back-to-back byte");
        rd(1, 2, "R7 back-to-back register even");
        rd(1, 3, "R7 back-to-back register odd");

        // R6 R8 external tier with wrap
        sram[800] = 32'hFFFF_FFFF;
        exp_sram[800] = 32'hFFFF_FFFF;
        log_q.delete();
        send(4'b0011, 12'd40, 16'd200);
        check("R8 cmd_ready low while external busy", 32'(cmd_ready), 32'd0);
        wait_idle();
        check("R6 wrap of external packet word", sram[800], 32'd0);
        check("R8 external byte word", sram[801], 32'd40);
        check("R8 access count", 32'(log_q.size()), 32'd4);
        if (log_q.size() == 4) begin
            check("R8 first access read packet", 32'(log_q[0]), {13'd0, 1'b0, 18'd800});
            check("R8 second access write packet", 32'(log_q[1]), {13'd0, 1'b1, 18'd800});
            check("R8 third access read byte", 32'(log_q[2]), {13'd0, 1'b0, 18'd801});
            check("R8 fourth access write byte", 32'(log_q[3]), {13'd0, 1'b1, 18'd801});
        end
        send(4'b0101, 12'd11, 16'hFFFF);
        wait_idle();
        check("R8 top index post byte", sram[int'({16'hFFFF, 2'b11})], 32'd11);

        // R7 back-to-back external commands to one index
        send(4'b0111, 12'd2, 16'd300);
        send(4'b0111, 12'd2, 16'd300);
        wait_idle();
        check("R7 external packet after two", sram[300*4+2], exp_sram[300*4+2]);
        check("R7 external byte after two", sram[300*4+3], exp_sram[300*4+3]);
        check("R9 request held until ack", 32'(hold_errs), 32'd0);
        rd(0, 800 % 512, "R8 external command leaves on-chip word alone");

        repeat (4) @(negedge clk);
        check("R10 scoreboard drained", 32'(exp_q.size()), 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule